// File: doc/BRIEF.md
# PCI Transaction Phase Monitor

This block watches the control strobes of a conventional PCI bus and reports, clock by clock, which phase the current transaction is in. It never drives the bus. On each rising edge it samples the cycle-frame, initiator-ready, target-ready, device-select and stop strobes, all active-low. From these it reports the address phase, each completed data phase, each wait cycle, the final data phase and the return to idle. It also reports every clock on which the target asks the master to stop.

Every output is a register loaded from the bus values taken at the latest rising edge. A pulse therefore appears for exactly one clock, just after the edge on which its bus condition was seen. A counter gives the number of data phases completed so far in the current transaction. A flag shows whether any target has claimed the transaction. A block such as a performance counter, a protocol checker or a trace unit can use these outputs without decoding the handshake again.

Top module: `pci_phase_monitor`

## Requirements
- R1: When the monitor is idle and the frame strobe is sampled low, `addr_phase_o` is 1 for exactly one clock and the monitor enters the transaction.
- R2: Inside a transaction, `data_done_o` is 1 for each sampled clock on which the initiator-ready and target-ready strobes are both low.
- R3: Inside a transaction, `wait_cycle_o` is 1 for each sampled clock on which the two ready strobes are not both low. The clock that ends the transaction is excluded. `wait_cycle_o` and `data_done_o` are never 1 together.
- R4: `last_data_o` is 1, together with `data_done_o`, on a completing data phase that is sampled with the frame strobe high.
- R5: `txn_end_o` is 1 for one clock on the first sampled clock with the initiator-ready strobe high after the last data phase. It is also 1 on a clock inside the transaction on which frame and initiator-ready are both sampled high, which is a transaction with no data.
- R6: `phase_count_o` is cleared to 0 on every address phase. It rises by one on every completed data phase and stays at 2^CNT_W-1 once it has reached that value.
- R7: `target_sel_o` becomes 1 once the device-select strobe is sampled low during a transaction. It is cleared by the next address phase and keeps its value in between, including after the transaction ends.
- R8: `stop_req_o` is 1 for each clock inside a transaction on which the stop strobe is sampled low.
- R9: If the frame strobe is sampled low on the same clock that ends a transaction after its last data phase, `txn_end_o` and `addr_phase_o` are both 1 on that clock. The count restarts at 0.
- R10: While idle with the frame strobe high, activity on the ready, select and stop strobes changes no output.
- R11: During synchronous active-low reset and right after it, all pulses, the count and the flag are 0. Every output reflects the strobes sampled at the most recent rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; strobes sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Cycle frame strobe, active low |
| irdy_n | input | 1 | Initiator ready strobe, active low |
| trdy_n | input | 1 | Target ready strobe, active low |
| devsel_n | input | 1 | Device select strobe, active low |
| stop_n | input | 1 | Target stop request strobe, active low |
| addr_phase_o | output | 1 | Pulse on the address phase |
| data_done_o | output | 1 | Pulse on each completed data phase |
| wait_cycle_o | output | 1 | Pulse on each wait cycle |
| last_data_o | output | 1 | Pulse on the final data phase |
| txn_end_o | output | 1 | Pulse on the return to idle |
| stop_req_o | output | 1 | Pulse while the target requests a stop |
| phase_count_o | output | CNT_W | Data phases completed in this transaction |
| target_sel_o | output | 1 | A target claimed this transaction |

## Verification
The end of one transaction and the address phase of the next can fall in the same clock. The bench provokes this by reasserting the frame strobe on the very clock where the initiator-ready strobe is released after a last data phase. It judges the result by requiring both pulses in that clock, with the count back at zero and the following data phase counted as the first. A second overlap comes from a stop request that arrives with a final completing data phase. That clock must carry the data-done, last-data and stop pulses together, and no wait pulse.

// File: rtl/pci_mon_pkg.sv
// Package: shared types for the PCI phase monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package pci_mon_pkg;

    // Tracking state of the monitor.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no transaction seen
        ST_BUSY = 2'd1,   // address phase seen, data phases running
        ST_TAIL = 2'd2    // last data phase done, waiting for initiator release
    } mon_state_e;

    // One-clock event flags produced by the phase tracker.
    typedef struct packed {
        logic addr;     // address phase
        logic done;     // data phase completed
        logic wt;       // wait cycle
        logic last;     // final data phase
        logic fin;      // return to idle
        logic stopreq;  // target stop request
    } mon_evt_t;

endpackage

// File: rtl/pci_mon_decode.sv
// Module: pci_mon_decode
// Turns the active-low bus strobes into active-high conditions.
// Assumes: strobes are already synchronous to clk, since they come from
// the same bus clock domain.
module pci_mon_decode (
    input  logic frame_n,
    input  logic irdy_n,
    input  logic trdy_n,
    input  logic devsel_n,
    input  logic stop_n,
    output logic frame,
    output logic irdy,
    output logic xfer,
    output logic devsel,
    output logic stop
);

    // Polarity conversion and the handshake completion condition.
    always_comb begin
        frame  = ~frame_n;
        irdy   = ~irdy_n;
        devsel = ~devsel_n;
        stop   = ~stop_n;
        xfer   = ~irdy_n & ~trdy_n;
    end

endmodule

// File: rtl/pci_mon_fsm.sv
// Module: pci_mon_fsm
// Tracks the transaction phase and produces the event flags. The flags
// come out both as combinational next values (evt) and as registered
// outputs (evt_q) loaded from the strobes sampled on this edge.
// Assumes: decoded active-high inputs and a synchronous active-low reset.
module pci_mon_fsm
    import pci_mon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame,
    input  logic     irdy,
    input  logic     xfer,
    input  logic     stop,
    output mon_evt_t evt,
    output mon_evt_t evt_q,
    output logic     in_txn
);

    mon_state_e state_q, state_d;

    // Next state and event flags, computed from the state and the current strobes.
    always_comb begin
        state_d = state_q;
        evt     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (frame) begin
                    evt.addr = 1'b1;
                    state_d  = ST_BUSY;
                end
            end
            ST_BUSY: begin
                evt.stopreq = stop;
                if (xfer) begin
                    evt.done = 1'b1;
                    if (!frame) begin
                        evt.last = 1'b1;
                        state_d  = ST_TAIL;
                    end
                end else if (!frame && !irdy) begin
                    evt.fin = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    evt.wt = 1'b1;
                end
            end
            ST_TAIL: begin
                if (!irdy) begin
                    evt.fin = 1'b1;
                    if (frame) begin
                        evt.addr = 1'b1;
                        state_d  = ST_BUSY;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and registered event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            evt_q   <= '0;
        end else begin
            state_q <= state_d;
            evt_q   <= evt;
        end
    end

    // Transaction is in its data portion, where select is meaningful.
    always_comb in_txn = (state_q == ST_BUSY);

endmodule

// File: rtl/pci_mon_counter.sv
// Module: pci_mon_counter
// Holds the saturating data-phase count and the sticky target-claimed flag.
// Both are cleared by an address phase.
// Assumes: addr_ev and done_ev are never high together (the tracker
// guarantees this).
module pci_mon_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_ev,
    input  logic             done_ev,
    input  logic             in_txn,
    input  logic             devsel,
    output logic [CNT_W-1:0] count_q,
    output logic             target_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Phase count: clear on address, step on done, hold at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (addr_ev) begin
            count_q <= '0;
        end else if (done_ev && (count_q != CNT_MAX)) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Target flag: clear on address, set when select is seen mid-transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= 1'b0;
        end else if (addr_ev) begin
            target_q <= 1'b0;
        end else if (in_txn && devsel) begin
            target_q <= 1'b1;
        end
    end

endmodule

// File: rtl/pci_phase_monitor.sv
// Module: pci_phase_monitor
// Passive PCI transaction phase monitor. It samples the bus strobes on each
// rising edge and reports phase events, a data-phase count and a
// target-claimed flag. It only observes and never drives the bus.
// Assumes: all strobes are active-low and synchronous to clk.
module pci_phase_monitor
    import pci_mon_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             trdy_n,
    input  logic             devsel_n,
    input  logic             stop_n,
    output logic             addr_phase_o,
    output logic             data_done_o,
    output logic             wait_cycle_o,
    output logic             last_data_o,
    output logic             txn_end_o,
    output logic             stop_req_o,
    output logic [CNT_W-1:0] phase_count_o,
    output logic             target_sel_o
);

    logic     frame, irdy, xfer, devsel, stop, in_txn;
    mon_evt_t evt, evt_q;

    pci_mon_decode u_decode (
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .trdy_n   (trdy_n),
        .devsel_n (devsel_n),
        .stop_n   (stop_n),
        .frame    (frame),
        .irdy     (irdy),
        .xfer     (xfer),
        .devsel   (devsel),
        .stop     (stop)
    );

    pci_mon_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .frame  (frame),
        .irdy   (irdy),
        .xfer   (xfer),
        .stop   (stop),
        .evt    (evt),
        .evt_q  (evt_q),
        .in_txn (in_txn)
    );

    pci_mon_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_ev  (evt.addr),
        .done_ev  (evt.done),
        .in_txn   (in_txn),
        .devsel   (devsel),
        .count_q  (phase_count_o),
        .target_q (target_sel_o)
    );

    // Drive the event pulses from the registered tracker flags.
    always_comb begin
        addr_phase_o = evt_q.addr;
        data_done_o  = evt_q.done;
        wait_cycle_o = evt_q.wt;
        last_data_o  = evt_q.last;
        txn_end_o    = evt_q.fin;
        stop_req_o   = evt_q.stopreq;
    end

endmodule

// File: rtl/pci_phase_monitor_chk.sv
// Module: pci_phase_monitor_chk
// Checker for the phase monitor, relating outputs to the strobes sampled on
// the previous edge. It is attached to every instance through bind.
// Assumes: the same synchronous active-low reset as the monitor.
module pci_phase_monitor_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_n,
    input logic             irdy_n,
    input logic             trdy_n,
    input logic             stop_n,
    input logic             addr_phase_o,
    input logic             data_done_o,
    input logic             wait_cycle_o,
    input logic             last_data_o,
    input logic             txn_end_o,
    input logic             stop_req_o,
    input logic [CNT_W-1:0] phase_count_o
);

    AST_ADDR_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase_o |-> !$past(frame_n)); // R1
    AST_DONE_NEEDS_BOTH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        data_done_o |-> (!$past(irdy_n) && !$past(trdy_n))); // R2
    AST_WAIT_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wait_cycle_o, data_done_o})); // R3
    AST_LAST_IS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        last_data_o |-> (data_done_o && $past(frame_n))); // R4
    AST_END_NEEDS_IRDY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        txn_end_o |-> $past(irdy_n)); // R5
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_done_o && !addr_phase_o) |->
        ((phase_count_o == $past(phase_count_o) + 1'b1) ||
         ((&phase_count_o) && (&$past(phase_count_o))))); // R6
    AST_ADDR_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase_o |-> (phase_count_o == '0)); // R6
    AST_STOP_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req_o |-> !$past(stop_n)); // R8

endmodule

bind pci_phase_monitor pci_phase_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_n       (frame_n),
    .irdy_n        (irdy_n),
    .trdy_n        (trdy_n),
    .stop_n        (stop_n),
    .addr_phase_o  (addr_phase_o),
    .data_done_o   (data_done_o),
    .wait_cycle_o  (wait_cycle_o),
    .last_data_o   (last_data_o),
    .txn_end_o     (txn_end_o),
    .stop_req_o    (stop_req_o),
    .phase_count_o (phase_count_o)
);

// File: tb/tb_pci_phase_monitor.sv
`timescale 1ns/1ps
module tb_pci_phase_monitor;

    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, devsel_n = 1'b1, stop_n = 1'b1;
    logic addr_phase_o, data_done_o, wait_cycle_o, last_data_o, txn_end_o, stop_req_o;
    logic [CNT_W-1:0] phase_count_o;
    logic target_sel_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk; // 125 MHz

    pci_phase_monitor #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n),
        .addr_phase_o(addr_phase_o), .data_done_o(data_done_o),
        .wait_cycle_o(wait_cycle_o), .last_data_o(last_data_o),
        .txn_end_o(txn_end_o), .stop_req_o(stop_req_o),
        .phase_count_o(phase_count_o), .target_sel_o(target_sel_o)
    );

    // Pulse vector order: addr, done, wait, last, end, stop
    function automatic logic [5:0] pulses();
        return {addr_phase_o, data_done_o, wait_cycle_o, last_data_o, txn_end_o, stop_req_o};
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic chk_p(input string req, input logic [5:0] exp);
        checks++;
        if (pulses() !== exp) begin
            failures++;
            $display("FAIL %s pulses(a,d,w,l,e,s): actual=%b expected=%b", req, pulses(), exp);
        end
    endtask

    // Drive one clock of strobes, then sample just after the edge that takes them.
    task automatic step(input logic f, input logic i, input logic t, input logic d, input logic s);
        @(negedge clk);
        frame_n = f; irdy_n = i; trdy_n = t; devsel_n = d; stop_n = s;
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        chk_p("R11", 6'b000000);
        chk("R11", "count", int'(phase_count_o), 0);
        chk("R11", "target", int'(target_sel_o), 0);
    endtask

    task automatic t_single();
        step(0,1,1,1,1); chk_p("R1", 6'b100000);
        step(1,0,0,0,1); chk_p("R4", 6'b010100);
        chk("R6", "count", int'(phase_count_o), 1);
        chk("R7", "target", int'(target_sel_o), 1);
        step(1,1,1,1,1); chk_p("R5", 6'b000010);
        chk("R7", "target held", int'(target_sel_o), 1);
    endtask

    task automatic t_burst();
        step(0,1,1,1,1); chk_p("R1", 6'b100000);
        chk("R7", "target cleared", int'(target_sel_o), 0);
        chk("R6", "count cleared", int'(phase_count_o), 0);
        step(0,0,1,0,1); chk_p("R3", 6'b001000);
        step(0,0,0,0,1); chk_p("R2", 6'b010000);
        step(0,0,0,0,1); chk_p("R2", 6'b010000);
        chk("R6", "count", int'(phase_count_o), 2);
        step(1,0,0,0,1); chk_p("R4", 6'b010100);
        chk("R6", "count", int'(phase_count_o), 3);
        step(1,1,1,1,1); chk_p("R5", 6'b000010);
    endtask

    task automatic t_stop();
        step(0,1,1,1,1); chk_p("R1", 6'b100000);
        step(0,0,1,0,0); chk_p("R8", 6'b001001);
        step(1,0,0,0,0); chk_p("R8", 6'b010101);
        step(1,1,1,1,1); chk_p("R5", 6'b000010);
    endtask

    task automatic t_back_to_back();
        step(0,1,1,1,1); chk_p("R1", 6'b100000);
        step(1,0,0,0,1); chk_p("R4", 6'b010100);
        step(0,1,1,1,1); chk_p("R9", 6'b100010);
        chk("R9", "count restart", int'(phase_count_o), 0);
        step(1,0,0,0,1); chk_p("R9", 6'b010100);
        chk("R9", "count", int'(phase_count_o), 1);
        step(1,1,1,1,1); chk_p("R5", 6'b000010);
    endtask

    task automatic t_idle_ignored();
        step(1,0,0,0,0); chk_p("R10", 6'b000000);
        chk("R10", "count", int'(phase_count_o), 1);
        step(1,1,0,1,0); chk_p("R10", 6'b000000);
        chk("R10", "target", int'(target_sel_o), 1);
    endtask

    task automatic t_abort();
        step(0,1,1,1,1); chk_p("R1", 6'b100000);
        step(0,0,1,1,1); chk_p("R3", 6'b001000);
        step(1,0,1,1,1); chk_p("R3", 6'b001000);
        step(1,1,1,1,1); chk_p("R5", 6'b000010);
        chk("R7", "no target", int'(target_sel_o), 0);
        chk("R6", "count", int'(phase_count_o), 0);
    endtask

    task automatic t_saturate();
        step(0,1,1,1,1); chk_p("R1", 6'b100000);
        for (int k = 0; k < 260; k++) step(0,0,0,0,1);
        chk("R6", "saturated count", int'(phase_count_o), 255);
        step(1,0,0,0,1); chk_p("R4", 6'b010100);
        chk("R6", "held count", int'(phase_count_o), 255);
        step(1,1,1,1,1); chk_p("R5", 6'b000010);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        t_reset();
        t_single();
        t_burst();
        t_stop();
        t_back_to_back();
        t_idle_ignored();
        t_abort();
        t_saturate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule